// File: doc/BRIEF.md
# Iterative RC5 Cipher Core

This block encrypts or decrypts one RC5 block of two w-bit words. One round of hardware is reused for every round, so each round takes one clock cycle. The block holds no key expansion logic and no round-key memory. Instead it drives a round index, and the surrounding logic must return the two round keys for that index, S[2i] and S[2i+1], combinationally in the same cycle. The key words are added, or subtracted, in that cycle.

A block is written through a write strobe that is gated by a busy flag. The busy flag stays high while the rounds run and while an unread result waits. The result is taken through a ready flag and a read strobe. The direction is sampled with the write and held for the whole block. For an encryption the index steps upward from the whitening step at index 0 to the last round. For a decryption it steps downward and finishes with the un-whitening step at index 0. The word size, the round count and the rotator variant are parameters. Two configurations are the intended targets: 16-bit words with 24 rounds, and 32-bit words with 12 rounds.

Top module: `rc5_iter_core`

## Requirements
- R1: After reset, `busy` and `res_ready` are 0 and `rnd_idx` is 0.
- R2: With `dir_dec`=0 on an accepted write, word A is `blk_in[W-1:0]` and word B is `blk_in[2W-1:W]`. The result on `blk_out` uses the same layout. It is the RC5 ciphertext: first A+=S[0] and B+=S[1]; then, for i=1..R, A=((A^B)<<<B)+S[2i] and B=((B^A)<<<A)+S[2i+1]. All arithmetic is modulo 2^W, and a rotate uses only the low log2(W) bits of its amount.
- R3: With `dir_dec`=1, the block applies the exact inverse of R2. For i=R..1 it computes B=((B-S[2i+1])>>>A)^A and then A=((A-S[2i])>>>B)^B. It finishes with B-=S[1] and A-=S[0].
- R4: During an encryption, `rnd_idx` takes the values 0,1,...,R on consecutive cycles. The keys on `key_even` (S[2i]) and `key_odd` (S[2i+1]) are used in the cycle that shows index i.
- R5: During a decryption, `rnd_idx` takes the values R,R-1,...,0 on consecutive cycles, with the same key timing as R4.
- R6: `busy` rises on the cycle after an accepted write. `res_ready` rises exactly R+1 cycles after that write edge. `busy` stays high from acceptance until the result is read.
- R7: A write while `busy` is high is ignored, whether rounds are running or a result is waiting. A change of `dir_dec` during a block has no effect on that block.
- R8: While `res_ready` is high and `rd_en` is low, `res_ready` and `blk_out` hold. A cycle with `rd_en` high drops both `res_ready` and `busy` on the next cycle, and a new write is then accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_dec | input | 1 | 0 = encrypt, 1 = decrypt; sampled with an accepted write |
| wr_en | input | 1 | Write strobe for `blk_in` |
| blk_in | input | 2W | Input block, B in the upper word and A in the lower word |
| busy | output | 1 | A block is in progress or a result is unread |
| rnd_idx | output | clog2(R+1) | Round index whose keys are needed this cycle |
| key_even | input | W | Round key S[2*rnd_idx] |
| key_odd | input | W | Round key S[2*rnd_idx+1] |
| blk_out | output | 2W | Result block, same word layout as the input |
| res_ready | output | 1 | Result valid until read |
| rd_en | input | 1 | Read strobe that releases the result |

## Verification
The bound checker checks, on every cycle, the index stepping in both directions, the index bound, and the handshake. The handshake covers the result holding until it is read, the release after a read, `busy` covering `res_ready`, and the direction staying fixed while busy. Only the bench can show that the arithmetic is right. It sweeps many blocks through encryption and decryption against a reference computed from the round equations, and it decrypts every ciphertext back to its plaintext. The bench scenarios also show that stray writes and direction changes during a block leave the result intact, and that the result appears exactly R+1 cycles after the write.

// File: rtl/rc5_pkg.sv
package rc5_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2
   } core_state_e;

   typedef enum logic {
      DIR_ENC = 1'b0,
      DIR_DEC = 1'b1
   } dir_e;
endpackage

// File: rtl/rc5_rot.sv
module rc5_rot #(
   parameter int W      = 32,
   parameter bit LEFT   = 1'b1,
   parameter bit BARREL = 1'b1,
   localparam int LW    = $clog2(W)
) (
   input  logic [W-1:0]  x,
   input  logic [LW-1:0] amt,
   output logic [W-1:0]  y
);
   generate
      if (BARREL) begin : g_barrel
         logic [W-1:0] stage [0:LW];
         assign stage[0] = x;
         for (genvar k = 0; k < LW; k++) begin : g_stage
            localparam int SH = 1 << k;
            logic [W-1:0] moved;
            if (LEFT) begin : g_l
               assign moved = {stage[k][W-1-SH:0], stage[k][W-1:W-SH]};
            end else begin : g_r
               assign moved = {stage[k][SH-1:0], stage[k][W-1:SH]};
            end
            assign stage[k+1] = amt[k] ? moved : stage[k];
         end
         assign y = stage[LW];
      end else begin : g_shift
         logic [2*W-1:0] dbl;
         logic [2*W-1:0] shifted;
         assign dbl = {x, x};
         if (LEFT) begin : g_l
            assign shifted = dbl << amt;
            assign y = shifted[2*W-1:W];
         end else begin : g_r
            assign shifted = dbl >> amt;
            assign y = shifted[W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/rc5_enc_round.sv
module rc5_enc_round #(
   parameter int W      = 32,
   parameter bit BARREL = 1'b1,
   localparam int LW    = $clog2(W)
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] k_even,
   input  logic [W-1:0] k_odd,
   input  logic         whiten,
   output logic [W-1:0] a_nxt,
   output logic [W-1:0] b_nxt
);
   logic [W-1:0] mix_a, rot_a, new_a;
   logic [W-1:0] mix_b, rot_b;

   assign mix_a = a ^ b;
   rc5_rot #(.W(W), .LEFT(1'b1), .BARREL(BARREL)) u_rot_a (
      .x(mix_a), .amt(b[LW-1:0]), .y(rot_a));
   assign new_a = rot_a + k_even;

   assign mix_b = b ^ new_a;
   rc5_rot #(.W(W), .LEFT(1'b1), .BARREL(BARREL)) u_rot_b (
      .x(mix_b), .amt(new_a[LW-1:0]), .y(rot_b));

   always_comb begin
      if (whiten) begin
         a_nxt = a + k_even;
         b_nxt = b + k_odd;
      end else begin
         a_nxt = new_a;
         b_nxt = rot_b + k_odd;
      end
   end
endmodule

// File: rtl/rc5_dec_round.sv
module rc5_dec_round #(
   parameter int W      = 32,
   parameter bit BARREL = 1'b1,
   localparam int LW    = $clog2(W)
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] k_even,
   input  logic [W-1:0] k_odd,
   input  logic         unwhiten,
   output logic [W-1:0] a_nxt,
   output logic [W-1:0] b_nxt
);
   logic [W-1:0] diff_b, rot_b, new_b;
   logic [W-1:0] diff_a, rot_a;

   assign diff_b = b - k_odd;
   rc5_rot #(.W(W), .LEFT(1'b0), .BARREL(BARREL)) u_rot_b (
      .x(diff_b), .amt(a[LW-1:0]), .y(rot_b));
   assign new_b = rot_b ^ a;

   assign diff_a = a - k_even;
   rc5_rot #(.W(W), .LEFT(1'b0), .BARREL(BARREL)) u_rot_a (
      .x(diff_a), .amt(new_b[LW-1:0]), .y(rot_a));

   always_comb begin
      if (unwhiten) begin
         a_nxt = diff_a;
         b_nxt = diff_b;
      end else begin
         a_nxt = rot_a ^ new_b;
         b_nxt = new_b;
      end
   end
endmodule

// File: rtl/rc5_ctrl.sv
module rc5_ctrl
   import rc5_pkg::*;
#(
   parameter int R     = 12,
   localparam int RW   = $clog2(R+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          dir_in,
   input  logic          rd_en,
   output logic          load,
   output logic          step,
   output logic          edge_step,
   output dir_e          mode,
   output logic [RW-1:0] idx,
   output logic          busy,
   output logic          ready
);
   localparam logic [RW-1:0] IDX_LAST = RW'(R);
   localparam logic [RW-1:0] IDX_ZERO = '0;

   core_state_e state_q;
   dir_e        mode_q;
   logic [RW-1:0] cnt_q;
   logic        run_done;

   assign load      = wr_en && (state_q == ST_IDLE);
   assign step      = (state_q == ST_RUN);
   assign edge_step = (cnt_q == IDX_ZERO);
   assign run_done  = (mode_q == DIR_ENC) ? (cnt_q == IDX_LAST) : (cnt_q == IDX_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= DIR_ENC;
         cnt_q   <= IDX_ZERO;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (wr_en) begin
                  state_q <= ST_RUN;
                  mode_q  <= dir_e'(dir_in);
                  cnt_q   <= dir_in ? IDX_LAST : IDX_ZERO;
               end
            end
            ST_RUN: begin
               if (run_done) begin
                  state_q <= ST_HOLD;
                  cnt_q   <= IDX_ZERO;
               end else if (mode_q == DIR_ENC) begin
                  cnt_q <= cnt_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_HOLD: begin
               if (rd_en) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mode  = mode_q;
   assign idx   = cnt_q;
   assign busy  = (state_q != ST_IDLE);
   assign ready = (state_q == ST_HOLD);
endmodule

// File: rtl/rc5_datapath.sv
module rc5_datapath
   import rc5_pkg::*;
#(
   parameter int W      = 32,
   parameter bit BARREL = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic           edge_step,
   input  dir_e           mode,
   input  logic [2*W-1:0] blk_in,
   input  logic [W-1:0]   k_even,
   input  logic [W-1:0]   k_odd,
   output logic [2*W-1:0] blk_out
);
   logic [W-1:0] a_q, b_q;
   logic [W-1:0] enc_a, enc_b, dec_a, dec_b;

   rc5_enc_round #(.W(W), .BARREL(BARREL)) u_enc (
      .a(a_q), .b(b_q), .k_even(k_even), .k_odd(k_odd),
      .whiten(edge_step), .a_nxt(enc_a), .b_nxt(enc_b));

   rc5_dec_round #(.W(W), .BARREL(BARREL)) u_dec (
      .a(a_q), .b(b_q), .k_even(k_even), .k_odd(k_odd),
      .unwhiten(edge_step), .a_nxt(dec_a), .b_nxt(dec_b));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (load) begin
         a_q <= blk_in[W-1:0];
         b_q <= blk_in[2*W-1:W];
      end else if (step) begin
         a_q <= (mode == DIR_DEC) ? dec_a : enc_a;
         b_q <= (mode == DIR_DEC) ? dec_b : enc_b;
      end
   end

   assign blk_out = {b_q, a_q};
endmodule

// File: rtl/rc5_iter_core.sv
module rc5_iter_core
   import rc5_pkg::*;
#(
   parameter int W          = 32,
   parameter int R          = 12,
   parameter bit ROT_BARREL = 1'b1,
   localparam int RW        = $clog2(R+1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           dir_dec,
   input  logic           wr_en,
   input  logic [2*W-1:0] blk_in,
   output logic           busy,
   output logic [RW-1:0]  rnd_idx,
   input  logic [W-1:0]   key_even,
   input  logic [W-1:0]   key_odd,
   output logic [2*W-1:0] blk_out,
   output logic           res_ready,
   input  logic           rd_en
);
   generate
      if (W != 16 && W != 32 && W != 64) begin : g_bad_w
         $error("rc5_iter_core: W must be 16, 32 or 64");
      end
      if (R < 1 || R > 255) begin : g_bad_r
         $error("rc5_iter_core: R must lie in 1..255");
      end
   endgenerate

   logic load, step, edge_step;
   dir_e mode_q;

   rc5_ctrl #(.R(R)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .dir_in(dir_dec), .rd_en(rd_en),
      .load(load), .step(step), .edge_step(edge_step), .mode(mode_q),
      .idx(rnd_idx), .busy(busy), .ready(res_ready));

   rc5_datapath #(.W(W), .BARREL(ROT_BARREL)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .edge_step(edge_step),
      .mode(mode_q), .blk_in(blk_in), .k_even(key_even), .k_odd(key_odd),
      .blk_out(blk_out));
endmodule

// File: rtl/rc5_iter_core_chk.sv
module rc5_iter_core_chk #(
   parameter int W  = 32,
   parameter int R  = 12,
   parameter int RW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic           rd_en,
   input logic           busy,
   input logic           res_ready,
   input logic [RW-1:0]  rnd_idx,
   input logic [2*W-1:0] blk_out,
   input logic           mode_q
);
   localparam logic [RW-1:0] LAST = RW'(R);
   logic running;
   assign running = busy && !res_ready;

   p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_idx <= LAST);
   p_enc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      running && !mode_q && rnd_idx != LAST |=> running && rnd_idx == $past(rnd_idx) + 1'b1);
   p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      running && mode_q && rnd_idx != '0 |=> running && rnd_idx == $past(rnd_idx) - 1'b1);
   p_enc_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
      running && !mode_q && rnd_idx == LAST |=> res_ready);
   p_ready_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready |-> busy);
   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && wr_en |=> running);
   p_mode_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode_q));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready && !rd_en |=> res_ready && $stable(blk_out));
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready && rd_en |=> !res_ready && !busy);
endmodule

bind rc5_iter_core rc5_iter_core_chk #(.W(W), .R(R), .RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .busy(busy),
   .res_ready(res_ready), .rnd_idx(rnd_idx), .blk_out(blk_out), .mode_q(mode_q));

// File: tb/test_rc5_iter_core.sv
module test_rc5_iter_core;
   localparam int W  = 16;
   localparam int R  = 24;
   localparam int RW = $clog2(R+1);
   localparam int NK = 2*(R+1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_dec = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [2*W-1:0] blk_in = '0;
   logic busy, res_ready;
   logic [RW-1:0] rnd_idx;
   logic [W-1:0] key_even, key_odd;
   logic [2*W-1:0] blk_out;

   logic [W-1:0] skey [0:NK-1];
   int n_chk = 0, n_bad = 0, cyc = 0;

   always #2.5 clk = ~clk;

   rc5_iter_core #(.W(W), .R(R), .ROT_BARREL(1'b1)) i_rc5_iter_core (
      .clk(clk), .rst_n(rst_n), .dir_dec(dir_dec), .wr_en(wr_en), .blk_in(blk_in),
      .busy(busy), .rnd_idx(rnd_idx), .key_even(key_even), .key_odd(key_odd),
      .blk_out(blk_out), .res_ready(res_ready), .rd_en(rd_en));

   assign key_even = skey[2*int'(rnd_idx)];
   assign key_odd  = skey[2*int'(rnd_idx)+1];

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] rl(input logic [W-1:0] x, input int s);
      logic [2*W-1:0] d;
      d = {x, x} >> (W - (s % W));
      return d[W-1:0];
   endfunction

   function automatic logic [W-1:0] rr(input logic [W-1:0] x, input int s);
      logic [2*W-1:0] d;
      d = {x, x} >> (s % W);
      return d[W-1:0];
   endfunction

   function automatic logic [2*W-1:0] ref_enc(input logic [2*W-1:0] p);
      logic [W-1:0] a, b;
      a = p[W-1:0] + skey[0];
      b = p[2*W-1:W] + skey[1];
      for (int i = 1; i <= R; i++) begin
         a = rl(a ^ b, int'(b)) + skey[2*i];
         b = rl(b ^ a, int'(a)) + skey[2*i+1];
      end
      return {b, a};
   endfunction

   function automatic logic [2*W-1:0] ref_dec(input logic [2*W-1:0] c);
      logic [W-1:0] a, b;
      a = c[W-1:0];
      b = c[2*W-1:W];
      for (int i = R; i >= 1; i--) begin
         b = rr(b - skey[2*i+1], int'(a)) ^ a;
         a = rr(a - skey[2*i], int'(b)) ^ b;
      end
      return {b - skey[1], a - skey[0]};
   endfunction

   // Runs one block; stray > 0 injects an ignored write and direction flip at that run cycle
   task automatic run_block(input logic [2*W-1:0] data, input bit dec, input logic [2*W-1:0] exp,
                            input int stray, input bit hold_test);
      logic [2*W-1:0] held;
      @(negedge clk);
      wr_en = 1'b1; blk_in = data; dir_dec = dec;
      @(posedge clk);
      for (int k = 1; k <= R+1; k++) begin
         @(negedge clk);
         wr_en = 1'b0;
         if (k == stray) begin
            wr_en = 1'b1; blk_in = ~data; dir_dec = ~dec;
         end
         check(busy && !res_ready, "R6 busy while running", {busy, res_ready}, 2'b10);
         if (dec) check(int'(rnd_idx) == R-(k-1), "R5 index order", rnd_idx, R-(k-1));
         else     check(int'(rnd_idx) == k-1, "R4 index order", rnd_idx, k-1);
         @(posedge clk);
      end
      @(negedge clk);
      wr_en = 1'b0; dir_dec = dec;
      check(res_ready == 1'b1, "R6 ready after R+1 cycles", res_ready, 1);
      check(blk_out == exp, dec ? "R3 decrypt result" : "R2 encrypt result", blk_out, exp);
      if (hold_test) begin
         held = blk_out;
         wr_en = 1'b1; blk_in = ~data; dir_dec = ~dec;
         for (int k = 0; k < 5; k++) @(negedge clk);
         wr_en = 1'b0; dir_dec = dec;
         check(res_ready && busy, "R8 ready held", {res_ready, busy}, 2'b11);
         check(blk_out == held, "R7 write during hold ignored", blk_out, held);
      end
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(!res_ready && !busy, "R8 release after read", {res_ready, busy}, 2'b00);
      if (hold_test) begin
         @(negedge clk);
         check(!busy, "R7 no block accepted from held write", busy, 0);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      for (int j = 0; j < NK; j++) skey[j] = W'(16'hb7e1 + j * 16'h9e37 + (j * j) * 16'h0135);
      repeat (3) @(negedge clk);
      check(!busy && !res_ready && rnd_idx == '0, "R1 reset state", {busy, res_ready, rnd_idx}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !res_ready && rnd_idx == '0, "R1 idle after reset", {busy, res_ready, rnd_idx}, 0);

      for (int k = 0; k < 64; k++) begin
         logic [2*W-1:0] pt, ct;
         pt = (k == 0) ? '0 : (k == 1) ? '1 : (k == 2) ? 32'h0000_0001 :
              ((k * 32'h9E37_79B9) ^ (k << 7));
         ct = ref_enc(pt);
         check(ref_dec(ct) == pt, "R3 reference round trip", ref_dec(ct), pt);
         run_block(pt, 1'b0, ct, (k == 5) ? 3 : 0, k == 7);
         run_block(ct, 1'b1, pt, (k == 9) ? 10 : 0, k == 11);
         run_block(pt, 1'b1, ref_dec(pt), 0, 1'b0);
      end

      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule